// File: doc/BRIEF.md
# Half-Flash Converter Timing Controller

This block is the digital control side of a four-channel, two-step 8-bit analog-to-digital converter. A conversion begins with a bus strobe. The block latches a 2-bit channel address and decodes it to a one-hot channel select for the input multiplexer. It then steps through three phases: acquisition (the sampling switch is closed and the comparators auto-zero), coarse decision, and fine decision on the residue. A 4-bit coarse code and a 4-bit fine code come from the front end. The block joins them into an 8-bit result, presents it to a tri-state data pad and signals completion on an active-low interrupt.

Two pins select the operating style, and both are captured when a conversion starts. The bus-mode pin picks read-only operation or write-then-read operation. In read-only operation, read going low starts the conversion and the result appears while read is still held low. In write-then-read operation, the write strobe frames the sampling window and a later read collects the result. An early read cuts the fine phase short. The timing pin picks sample/hold or track/hold phase lengths. All phase lengths are whole cycles of the internal clock, rounded up from nanosecond figures.

Top module: `halfflash_ctrl`

## Requirements
- R1: After reset the interrupt and ready outputs are high (1), the drive enable is low, the result register reads 0, no phase output is active and channel 0 is selected.
- R2: The address is latched only on the strobe edge that starts a conversion. It is decoded one-hot onto `ch_sel`, with bit n selecting channel n, and later address changes have no effect until the next start.
- R3: The result is {coarse, fine}, upper nibble coarse. The coarse code is taken on the clock edge that leaves acquisition, and the fine code on the edge that completes the conversion.
- R4: In write-then-read mode the interrupt goes low ceil(700 ns / clock period) cycles after the edge that registered write falling when sample/hold is selected, or ceil(830 ns / period) cycles for track/hold. If write rises later than that, the interrupt goes low one cycle after the write-rise edge.
- R5: In write-then-read mode, read falling during the fine phase completes the conversion on that clock edge: the fine code is latched and the interrupt is low after that edge.
- R6: In read-only mode, read falling starts a conversion and ready is low from the start edge until completion. The fine phase begins ceil(300 ns / period) cycles after the start edge under sample/hold and ceil(240 ns / period) under track/hold. The interrupt goes low ceil(1020 ns / period) cycles after the start edge, and ready returns high at that time.
- R7: The drive enable is high only while the conversion is complete, chip select is low and read is low. On the edge that registers read rising, the interrupt returns high.
- R8: Write and read strobes seen while chip select is high (inactive) start nothing, finish nothing and leave the result register unchanged.
- R9: `bus_mode` = 0 selects read-only and 1 selects write-then-read. `sh_sel` = 1 selects sample/hold and 0 selects track/hold. Both are captured at the start edge, so changes during a conversion do not alter its timing.
- R10: `acq_o` is high exactly during acquisition and `hold_o` exactly during the fine phase, and never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Active-low power-on reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| addr | input | 2 | Channel address |
| bus_mode | input | 1 | 0 read-only, 1 write-then-read |
| sh_sel | input | 1 | 1 sample/hold timing, 0 track/hold timing |
| coarse_code | input | 4 | Coarse flash decision from front end |
| fine_code | input | 4 | Fine flash decision on residue from front end |
| ch_sel | output | 4 | One-hot multiplexer channel select |
| acq_o | output | 1 | Acquisition phase: sample switch closed, comparators auto-zero |
| hold_o | output | 1 | Fine phase: input held, coarse latched |
| rdy_n | output | 1 | Active-low busy indication in read-only mode |
| int_n | output | 1 | Active-low conversion-complete interrupt |
| db_en | output | 1 | Drive enable for the tri-state data pad |
| db_out | output | 8 | Result register toward the data pad |

## Verification
The bench's front-end model inverts its coarse code once hold is entered and inverts its fine code outside hold. A controller that takes either nibble one cycle off therefore returns a visibly wrong result. The address and both mode pins are changed right after each start, so a design that does not latch them selects the wrong channel or switches to the wrong phase length. Completion is timed to the cycle in both bus modes and both timings, including a write held longer than the conversion time and a read arriving in the middle of the fine phase. A design with an off-by-one counter or no early-read path misses those cycles. Strobes under an inactive chip select are applied to expose a design that does not qualify its edges.

// File: rtl/hfc_pkg.sv
`timescale 1ns/1ps
package hfc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_FINE = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  // Round a nanosecond figure up to whole clock cycles.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max_of3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Two-step result: coarse nibble on top of the fine nibble.
  function automatic logic [7:0] join_halves(input logic [3:0] hi, input logic [3:0] lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/hfc_strobe_edge.sv
`timescale 1ns/1ps
module hfc_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wr_n,
  input  logic rd_n,
  output logic wr_fall,
  output logic wr_rise,
  output logic rd_fall,
  output logic rd_rise
);

  logic wr_d;
  logic rd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_d <= 1'b1;
      rd_d <= 1'b1;
    end else begin
      wr_d <= wr_n;
      rd_d <= rd_n;
    end
  end

  // Edges only count while the chip is selected.
  assign wr_fall = ~cs_n &  wr_d & ~wr_n;
  assign wr_rise = ~cs_n & ~wr_d &  wr_n;
  assign rd_fall = ~cs_n &  rd_d & ~rd_n;
  assign rd_rise = ~cs_n & ~rd_d &  rd_n;

endmodule

// File: rtl/hfc_phase_timer.sv
`timescale 1ns/1ps
module hfc_phase_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] TOP = '1;

  // Counts edges since the start edge; the start edge itself loads 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= CNT_W'(1);
    end else if (run && (cnt != TOP)) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/hfc_chan_latch.sv
`timescale 1ns/1ps
module hfc_chan_latch #(
  parameter int CH_BITS = 2,
  localparam int N_CH = 1 << CH_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [CH_BITS-1:0] addr,
  output logic [N_CH-1:0]    ch_sel
);

  logic [CH_BITS-1:0] ch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q <= '0;
    end else if (load) begin
      ch_q <= addr;
    end
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_dec
    assign ch_sel[i] = (ch_q == CH_BITS'(i));
  end

endmodule

// File: rtl/hfc_sequencer.sv
`timescale 1ns/1ps
module hfc_sequencer
  import hfc_pkg::*;
#(
  parameter int HALF_W     = 4,
  parameter int CNT_W      = 7,
  parameter int SH_CONV_C  = 70,
  parameter int TH_CONV_C  = 83,
  parameter int RD_CONV_C  = 102,
  parameter int SH_ACQ_C   = 30,
  parameter int TH_ACQ_C   = 24,
  localparam int RES_W     = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              bus_mode,
  input  logic              sh_sel,
  input  logic              wr_fall,
  input  logic              wr_rise,
  input  logic              rd_fall,
  input  logic              rd_rise,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [HALF_W-1:0] coarse_code,
  input  logic [HALF_W-1:0] fine_code,
  output phase_e            phase,
  output logic              wr_mode_q,
  output logic              conv_start,
  output logic              coarse_take,
  output logic              fine_take,
  output logic [RES_W-1:0]  res_q,
  output logic              int_n,
  output logic              rdy_n,
  output logic              acq_o,
  output logic              hold_o,
  output logic              db_en
);

  logic              sh_q;
  logic [HALF_W-1:0] coarse_q;
  logic              int_q;
  logic [CNT_W-1:0]  conv_lim;
  logic [CNT_W-1:0]  acq_lim;
  logic              start_wr;
  logic              start_rd;
  logic              rel_take;
  logic              busy;

  always_comb begin
    if (wr_mode_q) begin
      conv_lim = sh_q ? CNT_W'(SH_CONV_C) : CNT_W'(TH_CONV_C);
    end else begin
      conv_lim = CNT_W'(RD_CONV_C);
    end
    acq_lim = sh_q ? CNT_W'(SH_ACQ_C) : CNT_W'(TH_ACQ_C);
  end

  assign busy        = (phase == PH_ACQ) || (phase == PH_FINE);
  assign start_wr    = wr_fall & bus_mode & ((phase == PH_IDLE) || (phase == PH_DONE));
  assign start_rd    = rd_fall & ~bus_mode & (phase == PH_IDLE);
  assign conv_start  = start_wr | start_rd;
  assign coarse_take = (phase == PH_ACQ) &
                       (wr_mode_q ? wr_rise : (cnt >= acq_lim));
  assign fine_take   = (phase == PH_FINE) &
                       ((wr_mode_q & rd_fall) | (cnt >= conv_lim));
  assign rel_take    = (phase == PH_DONE) & rd_rise & ~conv_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      wr_mode_q <= 1'b0;
      sh_q      <= 1'b0;
      coarse_q  <= '0;
      res_q     <= '0;
      int_q     <= 1'b1;
    end else if (conv_start) begin
      phase     <= PH_ACQ;
      wr_mode_q <= bus_mode;
      sh_q      <= sh_sel;
      int_q     <= 1'b1;
    end else if (coarse_take) begin
      phase    <= PH_FINE;
      coarse_q <= coarse_code;
    end else if (fine_take) begin
      phase <= PH_DONE;
      res_q <= join_halves(coarse_q, fine_code);
      int_q <= 1'b0;
    end else if (rel_take) begin
      phase <= PH_IDLE;
      int_q <= 1'b1;
    end
  end

  assign int_n  = int_q;
  assign rdy_n  = ~(busy & ~wr_mode_q);
  assign acq_o  = (phase == PH_ACQ);
  assign hold_o = (phase == PH_FINE);
  assign db_en  = (phase == PH_DONE) & ~rd_n & ~cs_n;

endmodule

// File: rtl/halfflash_ctrl.sv
`timescale 1ns/1ps
module halfflash_ctrl
  import hfc_pkg::*;
#(
  parameter int CLK_NS     = 10,
  parameter int CH_BITS    = 2,
  parameter int HALF_W     = 4,
  parameter int SH_CONV_NS = 700,
  parameter int TH_CONV_NS = 830,
  parameter int RD_CONV_NS = 1020,
  parameter int SH_ACQ_NS  = 300,
  parameter int TH_ACQ_NS  = 240,
  localparam int N_CH      = 1 << CH_BITS,
  localparam int RES_W     = 2 * HALF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               wr_n,
  input  logic               rd_n,
  input  logic [CH_BITS-1:0] addr,
  input  logic               bus_mode,
  input  logic               sh_sel,
  input  logic [HALF_W-1:0]  coarse_code,
  input  logic [HALF_W-1:0]  fine_code,
  output logic [N_CH-1:0]    ch_sel,
  output logic               acq_o,
  output logic               hold_o,
  output logic               rdy_n,
  output logic               int_n,
  output logic               db_en,
  output logic [RES_W-1:0]   db_out
);

  localparam int SH_CONV_C = ns_to_cyc(SH_CONV_NS, CLK_NS);
  localparam int TH_CONV_C = ns_to_cyc(TH_CONV_NS, CLK_NS);
  localparam int RD_CONV_C = ns_to_cyc(RD_CONV_NS, CLK_NS);
  localparam int SH_ACQ_C  = ns_to_cyc(SH_ACQ_NS, CLK_NS);
  localparam int TH_ACQ_C  = ns_to_cyc(TH_ACQ_NS, CLK_NS);
  localparam int MAX_C     = max_of3(SH_CONV_C, TH_CONV_C, RD_CONV_C);
  localparam int CNT_W     = $clog2(MAX_C + 2);

  // Named internal events, visible to the bound checker.
  logic             wr_fall;
  logic             wr_rise;
  logic             rd_fall;
  logic             rd_rise;
  logic             conv_start;
  logic             coarse_take;
  logic             fine_take;
  logic             wr_mode_q;
  logic             seq_busy;
  logic             seq_idle;
  logic [CNT_W-1:0] cnt;
  phase_e           phase;

  hfc_strobe_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .wr_n    (wr_n),
    .rd_n    (rd_n),
    .wr_fall (wr_fall),
    .wr_rise (wr_rise),
    .rd_fall (rd_fall),
    .rd_rise (rd_rise)
  );

  hfc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (conv_start),
    .run   (seq_busy),
    .cnt   (cnt)
  );

  hfc_chan_latch #(.CH_BITS(CH_BITS)) u_chan (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (conv_start),
    .addr   (addr),
    .ch_sel (ch_sel)
  );

  hfc_sequencer #(
    .HALF_W    (HALF_W),
    .CNT_W     (CNT_W),
    .SH_CONV_C (SH_CONV_C),
    .TH_CONV_C (TH_CONV_C),
    .RD_CONV_C (RD_CONV_C),
    .SH_ACQ_C  (SH_ACQ_C),
    .TH_ACQ_C  (TH_ACQ_C)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .rd_n        (rd_n),
    .bus_mode    (bus_mode),
    .sh_sel      (sh_sel),
    .wr_fall     (wr_fall),
    .wr_rise     (wr_rise),
    .rd_fall     (rd_fall),
    .rd_rise     (rd_rise),
    .cnt         (cnt),
    .coarse_code (coarse_code),
    .fine_code   (fine_code),
    .phase       (phase),
    .wr_mode_q   (wr_mode_q),
    .conv_start  (conv_start),
    .coarse_take (coarse_take),
    .fine_take   (fine_take),
    .res_q       (db_out),
    .int_n       (int_n),
    .rdy_n       (rdy_n),
    .acq_o       (acq_o),
    .hold_o      (hold_o),
    .db_en       (db_en)
  );

  assign seq_busy = (phase == PH_ACQ) || (phase == PH_FINE);
  assign seq_idle = (phase == PH_IDLE);

endmodule

// File: rtl/halfflash_ctrl_chk.sv
`timescale 1ns/1ps
module halfflash_ctrl_chk #(
  parameter int N_CH = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic            rd_n,
  input logic            int_n,
  input logic            rdy_n,
  input logic            acq_o,
  input logic            hold_o,
  input logic            db_en,
  input logic [N_CH-1:0] ch_sel,
  input logic            seq_busy,
  input logic            seq_idle,
  input logic            wr_mode_q
);

  // R2
  ch_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ch_sel) == 1);

  // R2
  ch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && $past(seq_busy)) |-> $stable(ch_sel));

  // R5
  early_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && wr_mode_q && !cs_n && $fell(rd_n)) |=> !int_n);

  // R6
  rdy_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |-> (int_n && !db_en));

  // R7
  int_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_n && !cs_n && $rose(rd_n)) |=> int_n);

  // R7
  bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_en |-> (!int_n && !rd_n && !cs_n));

  // R8
  cs_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && seq_idle) |=> seq_idle);

  // R10
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acq_o && hold_o));

  // R10
  acq_no_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_o |-> int_n);

endmodule

bind halfflash_ctrl halfflash_ctrl_chk #(.N_CH(N_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .rd_n      (rd_n),
  .int_n     (int_n),
  .rdy_n     (rdy_n),
  .acq_o     (acq_o),
  .hold_o    (hold_o),
  .db_en     (db_en),
  .ch_sel    (ch_sel),
  .seq_busy  (seq_busy),
  .seq_idle  (seq_idle),
  .wr_mode_q (wr_mode_q)
);

// File: tb/halfflash_ctrl_bench.sv
`timescale 1ns/1ps
module halfflash_ctrl_bench;

  localparam int CLK_NS = 10;
  localparam int GUARD  = 3000;

  function automatic int cyc_up(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  localparam int E_SH_CONV = cyc_up(700);
  localparam int E_TH_CONV = cyc_up(830);
  localparam int E_RD_CONV = cyc_up(1020);
  localparam int E_SH_ACQ  = cyc_up(300);
  localparam int E_TH_ACQ  = cyc_up(240);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       wr_n = 1'b1;
  logic       rd_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic       bus_mode = 1'b0;
  logic       sh_sel = 1'b0;
  logic [3:0] coarse_code;
  logic [3:0] fine_code;
  logic [3:0] ch_sel;
  logic       acq_o;
  logic       hold_o;
  logic       rdy_n;
  logic       int_n;
  logic       db_en;
  logic [7:0] db_out;

  logic [7:0] ref_v [4];
  int         cyc = 0;
  int         checks = 0;
  int         errors = 0;
  bit         summary_done = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  halfflash_ctrl u_halfflash_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .wr_n        (wr_n),
    .rd_n        (rd_n),
    .addr        (addr),
    .bus_mode    (bus_mode),
    .sh_sel      (sh_sel),
    .coarse_code (coarse_code),
    .fine_code   (fine_code),
    .ch_sel      (ch_sel),
    .acq_o       (acq_o),
    .hold_o      (hold_o),
    .rdy_n       (rdy_n),
    .int_n       (int_n),
    .db_en       (db_en),
    .db_out      (db_out)
  );

  // Front-end model: codes are only correct inside the window where the
  // controller should take them, so a mistimed latch shows up in the result.
  always_comb begin
    int idx;
    idx = 0;
    for (int i = 0; i < 4; i++) if (ch_sel[i]) idx = i;
    coarse_code = hold_o ? ~ref_v[idx][7:4] : ref_v[idx][7:4];
    fine_code   = hold_o ?  ref_v[idx][3:0] : ~ref_v[idx][3:0];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic wait_int_low();
    int n;
    n = 0;
    while (int_n && n < GUARD) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic release_read(input string tag);
    rd_n = 1'b1;
    @(negedge clk);
    chk(int_n == 1'b1, {tag, " R7 int released"}, int_n, 1);
    chk(db_en == 1'b0, {tag, " R7 bus released"}, db_en, 0);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  // Write-then-read conversion. wr_len: cycles write is held low.
  // early: 0 for a normal read, else cycles after write rise for an early read.
  task automatic wr_conv(input int ch, input bit sh, input int wr_len, input int early);
    int t0;
    int lim;
    int exp_t;
    @(negedge clk);
    addr = 2'(ch); sh_sel = sh; bus_mode = 1'b1; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    t0 = cyc;
    chk(ch_sel == 4'(1 << ch), "R2 channel decode", ch_sel, 1 << ch);
    chk(acq_o == 1'b1 && hold_o == 1'b0, "R10 acquisition phase", {acq_o, hold_o}, 2);
    addr = 2'(ch ^ 1); sh_sel = ~sh; bus_mode = 1'b0;
    repeat (wr_len - 1) @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    chk(ch_sel == 4'(1 << ch), "R2 address held", ch_sel, 1 << ch);
    lim = sh ? E_SH_CONV : E_TH_CONV;
    if (early != 0) begin
      repeat (early - 1) @(negedge clk);
      chk(hold_o == 1'b1 && int_n == 1'b1, "R10 fine phase before early read", {hold_o, int_n}, 3);
      rd_n = 1'b0;
      @(negedge clk);
      chk(int_n == 1'b0, "R5 early read completes", int_n, 0);
      chk(db_en == 1'b1, "R7 bus driven on early read", db_en, 1);
      chk(db_out == ref_v[ch], "R5 R3 early result", db_out, ref_v[ch]);
    end else begin
      chk(hold_o == 1'b1 && acq_o == 1'b0 || wr_len >= lim, "R10 hold after write rise",
          {acq_o, hold_o}, 1);
      wait_int_low();
      exp_t = (wr_len + 1 > lim) ? wr_len + 1 : lim;
      chk(cyc - t0 == exp_t, "R4 R9 write-mode conversion time", cyc - t0, exp_t);
      chk(rdy_n == 1'b1, "R6 ready unused in write mode", rdy_n, 1);
      rd_n = 1'b0;
      @(negedge clk);
      chk(db_en == 1'b1, "R7 bus driven", db_en, 1);
      chk(db_out == ref_v[ch], "R3 write-mode result", db_out, ref_v[ch]);
    end
    release_read("wr");
  endtask

  task automatic rd_conv(input int ch, input bit sh);
    int t0;
    int acq;
    int conv;
    @(negedge clk);
    addr = 2'(ch); sh_sel = sh; bus_mode = 1'b0; cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    t0 = cyc;
    chk(rdy_n == 1'b0, "R6 ready low at start", rdy_n, 0);
    chk(acq_o == 1'b1, "R10 acquisition in read mode", acq_o, 1);
    chk(db_en == 1'b0, "R7 bus idle while busy", db_en, 0);
    addr = 2'(ch ^ 2); sh_sel = ~sh; bus_mode = 1'b1;
    acq = sh ? E_SH_ACQ : E_TH_ACQ;
    begin
      int n;
      n = 0;
      while (!hold_o && n < GUARD) begin
        @(negedge clk);
        n++;
      end
    end
    chk(cyc - t0 == acq, "R6 R9 acquisition length", cyc - t0, acq);
    wait_int_low();
    conv = E_RD_CONV;
    chk(cyc - t0 == conv, "R6 read-mode conversion time", cyc - t0, conv);
    chk(rdy_n == 1'b1, "R6 ready high at completion", rdy_n, 1);
    chk(db_en == 1'b1, "R7 bus driven in read mode", db_en, 1);
    chk(db_out == ref_v[ch], "R3 R2 read-mode result", db_out, ref_v[ch]);
    release_read("rd");
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog actual=hang expected=finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) ref_v[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(int_n == 1'b1 && rdy_n == 1'b1, "R1 handshakes after reset", {int_n, rdy_n}, 3);
    chk(db_en == 1'b0 && db_out == 8'h00, "R1 bus and result after reset", db_out, 0);
    chk(acq_o == 1'b0 && hold_o == 1'b0, "R1 no phase after reset", {acq_o, hold_o}, 0);
    chk(ch_sel == 4'b0001, "R1 channel after reset", ch_sel, 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int seed = 0; seed < 3; seed++) begin
      for (int c = 0; c < 4; c++) begin
        if (seed == 0) ref_v[c] = (c == 0) ? 8'h00 : (c == 1) ? 8'hFF : (c == 2) ? 8'h5A : 8'hA5;
        else ref_v[c] = 8'((seed * 37 + c * 71 + 5) & 255);
      end
      for (int sh = 0; sh < 2; sh++) begin
        for (int c = 0; c < 4; c++) begin
          wr_conv(c, sh[0], 20 + seed * 5, 0);
          rd_conv(c, sh[0]);
        end
      end
    end

    // Write held beyond the conversion time.
    ref_v[3] = 8'hC3;
    wr_conv(3, 1'b1, 90, 0);
    wr_conv(3, 1'b0, 95, 0);

    // Early reads in both timings.
    ref_v[1] = 8'h6E;
    wr_conv(1, 1'b1, 20, 10);
    ref_v[2] = 8'h9B;
    wr_conv(2, 1'b0, 32, 5);

    // R8: strobes with chip select inactive.
    begin
      logic [7:0] prev;
      prev = db_out;
      @(negedge clk);
      cs_n = 1'b1; bus_mode = 1'b1; wr_n = 1'b0;
      repeat (4) @(negedge clk);
      wr_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(acq_o == 1'b0 && hold_o == 1'b0, "R8 write ignored", {acq_o, hold_o}, 0);
      bus_mode = 1'b0; rd_n = 1'b0;
      repeat (4) @(negedge clk);
      chk(rdy_n == 1'b1 && acq_o == 1'b0, "R8 read ignored", {rdy_n, acq_o}, 2);
      chk(int_n == 1'b1 && db_en == 1'b0, "R8 no completion", {int_n, db_en}, 2);
      rd_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(db_out == prev, "R8 result unchanged", db_out, prev);
    end

    finish_run();
  end

endmodule